// File: doc/BRIEF.md
# Video PLL Lock Retry Sequencer

This block brings a video clock synthesizer up to a usable locked state. On a start strobe it issues a one-cycle GO request to the synthesizer's control logic. It then leaves one cycle of dead time and opens a window of exactly 1000 reference-clock ticks. On the last tick of that window it checks a qualified status word and the GO readback bit. A lock reported after the window closes is not trusted, because such a late lock is prone to jitter. So the block does not poll a single lock bit indefinitely. Each attempt gets a fixed window, and a failed attempt is answered by a fresh GO request.

At most 20 attempts are made. After the first good attempt the block stops, raises done and reports how many attempts it used. If all 20 attempts fail, it raises error with the attempt count at its limit. Done and error stay set until the next start strobe begins a new sequence. The surrounding controller uses done to move on to the next configuration step.

Top module: `vpll_lock_seq`

## Requirements
- R1: After synchronous reset `go_o`, `done_o` and `err_o` are 0 and `tries_o` is 0. Asserting reset in the middle of a sequence abandons it, and no GO follows until a new start.
- R2: A `start_i` seen while idle, done or failed clears `done_o`, `err_o` and the count. GO then pulses high for exactly one cycle in the next cycle, and `tries_o` shows the number of the attempt, counting from 1, during each pulse.
- R3: After each GO pulse one dead cycle follows. The window then counts only cycles with `ref_tick_i` high, ignoring ticks in the GO and dead cycles. Status is judged in the cycle of the 1000th counted tick only, so a good status at tick 999 or 1001 does not pass.
- R4: Status qualifies when `(stat_i & 8'h6F) == 8'h03`. Bit 0 (control reset finished) and bit 1 (locked) must be 1. Bit 2 (recalibrating), bit 3 (reference lost), bit 5 (excess jitter) and bit 6 (bypassed) must be 0. Bits 4 and 7 are ignored.
- R5: An attempt passes only if `go_rb_i` is also 0 in the judging cycle; otherwise it counts as failed.
- R6: After a passing attempt `done_o` rises, no further GO is issued, and `tries_o` holds the number of the passing attempt.
- R7: At most 20 attempts are made. If the 20th fails, `err_o` rises with `tries_o` = 20 and no further GO is issued. A pass on the 20th attempt still gives done.
- R8: `done_o` and `err_o` are never both high, and each holds until the next start.
- R9: A `start_i` during an active sequence has no effect: the attempt count, the GO pulses and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for a bring-up sequence |
| stat_i | input | 8 | Synthesizer status word |
| go_rb_i | input | 1 | GO bit read back from the synthesizer control |
| ref_tick_i | input | 1 | One-cycle enable per reference-clock cycle |
| go_o | output | 1 | One-cycle GO request per attempt |
| done_o | output | 1 | Sequence ended with lock |
| err_o | output | 1 | Sequence ended after the attempt limit |
| tries_o | output | $clog2(MAX_TRIES+1) = 5 | Attempts issued in the current sequence |

## Verification
A window counter that is off by one tick shows up at the ports within a single attempt. The bench presents a good status for just one reference tick, so a window that ends early or late makes that attempt fail. The extra GO pulse appears about one window later. A wrong attempt count shows at once in `tries_o` during the next GO pulse, and at the end as an early or late error. A state that fails to hold done or error shows in the cycles after the result, and a start strobe that breaks in during a sequence shows as a GO pulse that restarts the count at 1.

// File: rtl/vpll_seq_pkg.sv
package vpll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GAP,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    localparam int          STAT_W     = 8;
    localparam logic [7:0]  LOCK_MASK  = 8'h6F;
    localparam logic [7:0]  LOCK_MATCH = 8'h03;

endpackage

// File: rtl/vpll_lock_qual.sv
module vpll_lock_qual #(
    parameter int               W     = 8,
    parameter logic [W-1:0]     MASK  = '1,
    parameter logic [W-1:0]     MATCH = '0
) (
    input  logic [W-1:0] stat_i,
    input  logic         go_rb_i,
    output logic         ok_o
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_care
            assign bit_ok[i] = (stat_i[i] == MATCH[i]);
        end else begin : g_skip
            assign bit_ok[i] = 1'b1;
        end
    end

    assign ok_o = (&bit_ok) && !go_rb_i;
endmodule

// File: rtl/vpll_tick_window.sv
module vpll_tick_window #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic en_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(TICKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = '0;
        end else if (en_i && tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last_o = en_i && tick_i && (cnt_q == CNT_W'(TICKS - 1));
endmodule

// File: rtl/vpll_lock_seq.sv
module vpll_lock_seq
    import vpll_seq_pkg::*;
#(
    parameter int WAIT_TICKS = 1000,
    parameter int MAX_TRIES  = 20,
    localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        stat_i,
    input  logic              go_rb_i,
    input  logic              ref_tick_i,
    output logic              go_o,
    output logic              done_o,
    output logic              err_o,
    output logic [TRY_W-1:0]  tries_o
);
    typedef struct packed {
        seq_state_e         st;
        logic [TRY_W-1:0]   tries;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic win_load, win_en, win_last, lock_ok;

    vpll_lock_qual #(
        .W     (STAT_W),
        .MASK  (LOCK_MASK),
        .MATCH (LOCK_MATCH)
    ) u_qual (
        .stat_i  (stat_i),
        .go_rb_i (go_rb_i),
        .ok_o    (lock_ok)
    );

    vpll_tick_window #(
        .TICKS (WAIT_TICKS)
    ) u_win (
        .clk    (clk),
        .rst    (rst),
        .load_i (win_load),
        .en_i   (win_en),
        .tick_i (ref_tick_i),
        .last_o (win_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        win_load = 1'b0;
        win_en   = 1'b0;
        case (ctl_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    ctl_d.st    = ST_PULSE;
                    ctl_d.tries = TRY_W'(1);
                end
            end
            ST_PULSE: begin
                win_load = 1'b1;
                ctl_d.st = ST_GAP;
            end
            ST_GAP: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                win_en = 1'b1;
                if (win_last) begin
                    if (lock_ok) begin
                        ctl_d.st = ST_DONE;
                    end else if (ctl_q.tries == TRY_W'(MAX_TRIES)) begin
                        ctl_d.st = ST_FAIL;
                    end else begin
                        ctl_d.st    = ST_PULSE;
                        ctl_d.tries = ctl_q.tries + TRY_W'(1);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.tries <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign go_o    = (ctl_q.st == ST_PULSE);
    assign done_o  = (ctl_q.st == ST_DONE);
    assign err_o   = (ctl_q.st == ST_FAIL);
    assign tries_o = ctl_q.tries;
endmodule

// File: rtl/vpll_lock_seq_chk.sv
module vpll_lock_seq_chk #(
    parameter int MAX_TRIES = 20,
    localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             go_o,
    input logic             done_o,
    input logic             err_o,
    input logic [TRY_W-1:0] tries_o
);
    assert_go_single_R2: assert property (@(posedge clk) disable iff (rst)
        go_o |=> !go_o);

    assert_go_numbering_R2: assert property (@(posedge clk) disable iff (rst)
        (go_o && tries_o != TRY_W'(1)) |-> tries_o == $past(tries_o) + TRY_W'(1));

    assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> err_o);

    assert_no_go_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        ((done_o || err_o) && !start_i) |=> !go_o);

    assert_err_at_limit_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |-> tries_o == TRY_W'(MAX_TRIES));

    assert_tries_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        tries_o <= TRY_W'(MAX_TRIES));
endmodule

bind vpll_lock_seq vpll_lock_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .go_o    (go_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .tries_o (tries_o)
);

// File: tb/vpll_lock_seq_test.sv
`timescale 1ns/1ps
module vpll_lock_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] stat_i;
    logic       go_rb_i;
    logic       ref_tick_i;
    logic       go_o, done_o, err_o;
    logic [4:0] tries_o;

    always #2.5 clk = ~clk;

    vpll_lock_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .stat_i(stat_i),
        .go_rb_i(go_rb_i), .ref_tick_i(ref_tick_i), .go_o(go_o),
        .done_o(done_o), .err_o(err_o), .tries_o(tries_o)
    );

    // synthesizer model configuration (written by the stimulus only)
    int         cfg_ga = 1;        // attempt that sees word_b at tick 1000
    logic [7:0] cfg_a = 8'h00;     // word for other attempts
    logic [7:0] cfg_b = 8'h03;
    int         cfg_per = 1;       // reference tick period in cycles
    int         cfg_gt = 1000;     // tick index for word_a
    int         cfg_stuck = 0;     // attempt whose GO readback never clears
    logic       new_seq = 1'b0;

    // synthesizer model state (written by the model only)
    int  attempt, tick_cnt, skip, phase, rb_cnt;
    bit  prev_go, double_go;

    always @(negedge clk) begin
        bit tick, counted;
        if (rst) begin
            attempt = 0; tick_cnt = 0; skip = 0; phase = 0; rb_cnt = 0;
            prev_go = 0; double_go = 0;
            stat_i = 8'h00; go_rb_i = 1'b0; ref_tick_i = 1'b0;
        end else begin
            if (new_seq) attempt = 0;
            if (go_o && prev_go) double_go = 1;
            prev_go = go_o;
            if (go_o) begin
                attempt = attempt + 1; tick_cnt = 0; skip = 2;
                go_rb_i = 1'b1; rb_cnt = 0;
            end else if (go_rb_i && attempt != cfg_stuck) begin
                rb_cnt = rb_cnt + 1;
                if (rb_cnt >= 4) go_rb_i = 1'b0;
            end
            phase = (phase + 1) % cfg_per;
            tick = (phase == 0);
            ref_tick_i = tick;
            counted = tick && (skip == 0);
            if (skip > 0) skip = skip - 1;
            if (counted) tick_cnt = tick_cnt + 1;
            stat_i = 8'h00;
            if (counted) begin
                if (attempt == cfg_ga && tick_cnt == 1000) stat_i = cfg_b;
                else if (attempt != cfg_ga && tick_cnt == cfg_gt) stat_i = cfg_a;
            end
        end
    end

    typedef struct packed {
        int         ga;
        logic [7:0] a;
        logic [7:0] b;
        int         per;
        int         gt;
        int         stuck;
        int         tries;
    } vec_t;

    // every vector ends in done with the given attempt count
    localparam vec_t VECS [10] = '{
        '{ga:1,  a:8'h00, b:8'h03, per:1, gt:1000, stuck:0, tries:1},  // R3 R6
        '{ga:2,  a:8'h43, b:8'h03, per:1, gt:1000, stuck:0, tries:2},  // R4 bypass
        '{ga:2,  a:8'h23, b:8'h13, per:3, gt:1000, stuck:0, tries:2},  // R4 jitter, bit4; R3 sparse ticks
        '{ga:2,  a:8'h0B, b:8'h83, per:1, gt:1000, stuck:0, tries:2},  // R4 ref lost, bit7
        '{ga:2,  a:8'h07, b:8'h03, per:2, gt:1000, stuck:0, tries:2},  // R4 recal
        '{ga:3,  a:8'h02, b:8'h03, per:1, gt:1000, stuck:0, tries:3},  // R4 no reset done
        '{ga:2,  a:8'h01, b:8'h03, per:1, gt:1000, stuck:0, tries:2},  // R4 no lock
        '{ga:2,  a:8'h03, b:8'h03, per:1, gt:1000, stuck:1, tries:2},  // R5 GO stuck
        '{ga:2,  a:8'h03, b:8'h03, per:1, gt:999,  stuck:0, tries:2},  // R3 early lock
        '{ga:20, a:8'h00, b:8'h03, per:1, gt:1000, stuck:0, tries:20}  // R7 last attempt
    };

    int tests = 0;
    int fails = 0;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input bit fresh);
        @(negedge clk); #1;
        start_i = 1'b1; new_seq = fresh;
        @(negedge clk); #1;
        start_i = 1'b0; new_seq = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while (!(done_o || err_o) && n < 80000) begin
            @(negedge clk); n++;
        end
        #1;
        if (n >= 80000) check({req, " watchdog"}, 0, 1);
    endtask

    task automatic check_result(input string req, input bit exp_done, input int exp_tries);
        check({req, " done"}, int'(done_o), int'(exp_done));
        check({req, " err"}, int'(err_o), int'(!exp_done));
        check({req, " tries"}, int'(tries_o), exp_tries);
        check({req, " go pulses"}, attempt, exp_tries);
        repeat (5) @(negedge clk);
        #1;
        check("R8 result held", int'(done_o), int'(exp_done));
        check("R6 R7 no GO after end", attempt, exp_tries);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset go", int'(go_o), 0);
        check("R1 reset done/err", int'(done_o | err_o), 0);
        check("R1 reset tries", int'(tries_o), 0);
        rst = 1'b0;

        // R2 GO timing: pulse the cycle after start, numbered 1
        pulse_start(1'b1);
        check("R2 go after start", int'(go_o), 1);
        check("R2 tries in pulse", int'(tries_o), 1);
        @(negedge clk); #1;
        check("R2 go single cycle", int'(go_o), 0);
        wait_end("R6 first try");
        check_result("R6 first try", 1'b1, 1);

        foreach (VECS[i]) begin
            cfg_ga = VECS[i].ga; cfg_a = VECS[i].a; cfg_b = VECS[i].b;
            cfg_per = VECS[i].per; cfg_gt = VECS[i].gt; cfg_stuck = VECS[i].stuck;
            pulse_start(1'b1);
            wait_end($sformatf("R4 vector %0d", i));
            check_result($sformatf("R3 R4 R5 vector %0d", i), 1'b1, VECS[i].tries);
        end

        // R3 late lock: good only at tick 1001 on attempt 1
        cfg_ga = 2; cfg_a = 8'h03; cfg_b = 8'h03; cfg_per = 1; cfg_gt = 1001; cfg_stuck = 0;
        pulse_start(1'b1);
        wait_end("R3 late lock");
        check_result("R3 late lock", 1'b1, 2);

        // R7 exhaustion
        cfg_ga = 0; cfg_a = 8'h00; cfg_gt = 1000;
        pulse_start(1'b1);
        wait_end("R7 exhaust");
        check_result("R7 exhaust", 1'b0, 20);

        // R2 restart from the failed state
        cfg_ga = 1;
        pulse_start(1'b1);
        check("R2 restart clears err", int'(err_o), 0);
        check("R2 restart tries", int'(tries_o), 1);
        wait_end("R2 restart");
        check_result("R2 restart", 1'b1, 1);

        // R9 start during active sequence is ignored
        cfg_ga = 2;
        pulse_start(1'b1);
        repeat (300) @(negedge clk);
        pulse_start(1'b0);
        #1;
        check("R9 tries unchanged", int'(tries_o), 1);
        wait_end("R9 ignored start");
        check_result("R9 ignored start", 1'b1, 2);

        // R1 reset mid-sequence
        pulse_start(1'b1);
        repeat (100) @(negedge clk);
        #1; rst = 1'b1;
        @(negedge clk); #1;
        check("R1 mid reset tries", int'(tries_o), 0);
        check("R1 mid reset go/done/err", int'(go_o | done_o | err_o), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk); #1;
        check("R1 idle after reset", int'(go_o | done_o | err_o), 0);

        check("R2 GO never two cycles", int'(double_go), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end
endmodule